// File: doc/BRIEF.md
# Serially Programmed Wiper Code Bank

This block is the digital core of a multi-channel digital potentiometer. A three-wire serial port (active-low select, serial clock, serial data) shifts words into an 11-bit shift register. When the select line returns high, the register contents are split into a 3-bit channel address and an 8-bit wiper code. The code is written into the addressed channel latch, and every other latch keeps its value. The channel count is a parameter, normally 4 or 6. Each latch drives one 8-bit slice of a flat output bus, which the analog ladder outside this block decodes.

The far end of the shift register drives a serial output, so several devices can be chained on one select line. The serial pins are brought into a single system clock domain through two-flop synchronizers, and their edges are detected there. A power-on reset or an asynchronous preset pin returns every latch to midscale. A shutdown request is passed through to a disconnect flag and does not touch the stored codes.

Top module: `wiper_bank_core`

## Requirements
- R1: A frame is the last 11 bits shifted before the select line rises. The first 3 of those bits are the address, most significant bit first. The last 8 are the code, most significant bit first. Bits shifted before the final 11 have no effect.
- R2: Shifting serial bits never changes any latch. A latch changes only after a low-to-high transition of the select line.
- R3: On a select rise with address k below NUM_CH, channel k (output bits [8k+7:8k]) takes the code. Every other channel is unchanged.
- R4: On a select rise with address NUM_CH or above, no channel changes.
- R5: While reset is asserted, every channel reads 0x80, the serial output reads 0 and the shutdown flag reads 0.
- R6: Driving the preset pin low forces every channel to 0x80 at once, with no clock needed, and holds them there while it stays low. The shift register contents are not disturbed.
- R7: Serial clock edges while the select line is high do not shift the register. A later select pulse with no clock edges reloads the frame that was last shifted in.
- R8: The serial output updates only on falling serial clock edges. It then presents the bit that entered the shift register 11 accepted rising edges earlier.
- R9: The shutdown flag follows the shutdown input within four system clocks, and shutdown leaves all channel codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csel_n_i | input | 1 | Active-low serial select, asynchronous |
| sdin_i | input | 1 | Serial data in, sampled on serial clock rise |
| preset_n_i | input | 1 | Asynchronous active-low midscale preset |
| shdn_i | input | 1 | Shutdown request, active high |
| ser_dout_o | output | 1 | Serial data out for chaining |
| shdn_o | output | 1 | Disconnect flag, active high |
| wiper_codes_o | output | NUM_CH*8 | Channel codes, channel k in bits [8k+7:8k] |

## Verification
The checker watches several rules on every cycle. Codes move only on a load strobe, and a load strobe writes exactly the addressed channel. An out-of-range address leaves every code still. A low preset means all codes sit at midscale. The shift register moves only after an accepted rising serial edge, and the serial output moves only on a falling edge and then carries the old top register bit. What the bench's scenarios alone can show is the mapping from serial bits to a channel's code. Those scenarios cover a sweep over all addresses and all 256 code values, frames longer than 11 bits, the reload of a held frame after a preset, and the 11-bit delay a downstream device sees.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int WBK_ADDR_W = 3;
  localparam int WBK_CODE_W = 8;
  localparam int WBK_SYNC_STAGES = 2;

  function automatic logic [WBK_CODE_W-1:0] wbk_midscale();
    logic [WBK_CODE_W-1:0] m;
    m = '0;
    m[WBK_CODE_W-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wbk_rst_sync.sv
module wbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_nxt;

  always_comb q_nxt = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_nxt;
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/wbk_sync_edge.sv
module wbk_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sq;
  logic [STAGES-1:0] sq_nxt;
  logic              prev;

  always_comb sq_nxt = {sq[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq   <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      sq   <= sq_nxt;
      prev <= sq[STAGES-1];
    end
  end

  assign level = sq[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/wbk_sync_bus.sv
module wbk_sync_bus #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wbk_shifter.sv
module wbk_shifter #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               out_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sreg,
  output logic               dout
);
  logic [FRAME_W-1:0] sreg_nxt;
  logic               dout_nxt;

  always_comb begin
    sreg_nxt = sreg;
    dout_nxt = dout;
    if (shift_en) sreg_nxt = {sreg[FRAME_W-2:0], din};
    if (out_en)   dout_nxt = sreg[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      dout <= 1'b0;
    end else begin
      sreg <= sreg_nxt;
      dout <= dout_nxt;
    end
  end
endmodule

// File: rtl/wbk_latch_bank.sv
module wbk_latch_bank
  import wbk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = WBK_ADDR_W,
  parameter int CODE_W = WBK_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_stb,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [CODE_W-1:0]        ld_code,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] cur;
    logic [CODE_W-1:0] nxt;

    assign hit = ld_stb && (ld_addr == ADDR_W'(ch));

    always_comb begin
      nxt = cur;
      if (hit) nxt = ld_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= MID;
      else        cur <= nxt;
    end

    assign codes[ch*CODE_W +: CODE_W] = cur;
  end
endmodule

// File: rtl/wiper_bank_core.sv
module wiper_bank_core
  import wbk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = WBK_ADDR_W,
  parameter int CODE_W = WBK_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     csel_n_i,
  input  logic                     sdin_i,
  input  logic                     preset_n_i,
  input  logic                     shdn_i,
  output logic                     ser_dout_o,
  output logic                     shdn_o,
  output logic [NUM_CH*CODE_W-1:0] wiper_codes_o
);
  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam int STAGES  = WBK_SYNC_STAGES;

  logic sys_rst_n;
  logic lat_rst_n;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic cs_lvl, cs_rise, cs_fall_unused;
  logic [1:0] misc_q;
  logic din_s;
  logic shift_en;
  logic ld_stb;
  logic [FRAME_W-1:0] sreg;
  logic [ADDR_W-1:0]  ld_addr;
  logic [CODE_W-1:0]  ld_code;

  wbk_rst_sync #(.STAGES(STAGES)) u_rst_sys (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  wbk_rst_sync #(.STAGES(STAGES)) u_rst_lat (
    .clk(clk), .arst_n(rst_n & preset_n_i), .srst_n(lat_rst_n));

  wbk_sync_edge #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(sys_rst_n), .d(sclk_i),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  wbk_sync_edge #(.STAGES(STAGES), .RST_VAL(1'b1)) u_csel (
    .clk(clk), .rst_n(sys_rst_n), .d(csel_n_i),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall_unused));

  wbk_sync_bus #(.W(2), .STAGES(STAGES)) u_misc (
    .clk(clk), .rst_n(sys_rst_n), .d({shdn_i, sdin_i}), .q(misc_q));

  assign din_s    = misc_q[0];
  assign shdn_o   = misc_q[1];
  assign shift_en = sclk_rise & ~cs_lvl;
  assign ld_stb   = cs_rise;

  wbk_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(sys_rst_n), .shift_en(shift_en), .out_en(sclk_fall),
    .din(din_s), .sreg(sreg), .dout(ser_dout_o));

  assign ld_addr = sreg[FRAME_W-1 -: ADDR_W];
  assign ld_code = sreg[CODE_W-1:0];

  wbk_latch_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(lat_rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_code(ld_code), .codes(wiper_codes_o));
endmodule

// File: rtl/wbk_checker.sv
module wbk_checker #(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 3,
  parameter int CODE_W  = 8,
  parameter int FRAME_W = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lat_rst_n,
  input logic                     cs_lvl,
  input logic                     sclk_lvl,
  input logic                     sclk_fall,
  input logic                     ld_stb,
  input logic [ADDR_W-1:0]        ld_addr,
  input logic [CODE_W-1:0]        ld_code,
  input logic [FRAME_W-1:0]       sreg,
  input logic                     ser_dout,
  input logic [NUM_CH*CODE_W-1:0] codes
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

  assert_hold_no_load_R2: assert property (@(posedge clk)
    disable iff (!rst_n || !lat_rst_n) !ld_stb |=> $stable(codes));

  assert_addr_range_R4: assert property (@(posedge clk)
    disable iff (!rst_n || !lat_rst_n)
    (ld_stb && (int'(ld_addr) >= NUM_CH)) |=> $stable(codes));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_load_R3: assert property (@(posedge clk)
      disable iff (!rst_n || !lat_rst_n)
      (ld_stb && (int'(ld_addr) == ch)) |=>
        (codes[ch*CODE_W +: CODE_W] == $past(ld_code)));

    assert_preset_mid_R6: assert property (@(posedge clk)
      disable iff (!rst_n)
      !lat_rst_n |-> (codes[ch*CODE_W +: CODE_W] == MID));
  end

  assert_shift_idle_R7: assert property (@(posedge clk)
    disable iff (!rst_n) cs_lvl |=> $stable(sreg));

  assert_shift_source_R7: assert property (@(posedge clk)
    disable iff (!rst_n) !$stable(sreg) |-> $past(!cs_lvl && sclk_lvl));

  assert_dout_quiet_R8: assert property (@(posedge clk)
    disable iff (!rst_n) !sclk_fall |=> $stable(ser_dout));

  assert_dout_tap_R8: assert property (@(posedge clk)
    disable iff (!rst_n) sclk_fall |=> (ser_dout == $past(sreg[FRAME_W-1])));
endmodule

bind wiper_bank_core wbk_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .FRAME_W(FRAME_W)
) u_wbk_checker (
  .clk(clk), .rst_n(sys_rst_n), .lat_rst_n(lat_rst_n), .cs_lvl(cs_lvl),
  .sclk_lvl(sclk_lvl), .sclk_fall(sclk_fall), .ld_stb(ld_stb),
  .ld_addr(ld_addr), .ld_code(ld_code), .sreg(sreg), .ser_dout(ser_dout_o),
  .codes(wiper_codes_o));

// File: tb/wiper_bank_core_bench.sv
module wiper_bank_core_bench;
  localparam int NCH = 4;
  localparam int H   = 4;

  logic clk = 1'b0;
  logic rst_n, sclk, csel_n, sdin, preset_n, shdn;
  logic dout, shdn_f;
  logic [NCH*8-1:0] codes;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  exp_code [NCH];
  logic [10:0] model;

  always #2.5 clk = ~clk;

  wiper_bank_core #(.NUM_CH(NCH)) u_wiper_bank_core (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csel_n_i(csel_n), .sdin_i(sdin),
    .preset_n_i(preset_n), .shdn_i(shdn), .ser_dout_o(dout), .shdn_o(shdn_f),
    .wiper_codes_o(codes));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) check(tag, 32'(codes[c*8 +: 8]), 32'(exp_code[c]));
  endtask

  task automatic send_bit(input logic b);
    sdin = b;
    tick(H);
    sclk = 1'b1;
    if (!csel_n) model = {model[9:0], b};
    tick(H);
    sclk = 1'b0;
    tick(H);
    check("R8 serial out", 32'(dout), 32'(model[10]));
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n, input int addr, input logic [7:0] code);
    csel_n = 1'b0;
    tick(H);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
    check_all("R2 no update before select rise");
    csel_n = 1'b1;
    tick(6);
    if (addr < NCH) exp_code[addr] = code;
    check_all(addr < NCH ? "R3 addressed load" : "R4 out-of-range address");
  endtask

  task automatic send_frame(input int addr, input logic [7:0] code);
    send_bits({5'b0, 3'(addr), code}, 11, addr, code);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; csel_n = 1'b1; sdin = 1'b0;
    preset_n = 1'b1; shdn = 1'b0;
    model = '0;
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    tick(5);
    check_all("R5 reset midscale");
    check("R5 reset serial out", 32'(dout), 32'h0);
    check("R5 reset shutdown flag", 32'(shdn_f), 32'h0);
    rst_n = 1'b1;
    tick(5);

    // R3 R4: every address with assorted codes including both extremes
    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 8; k++)
        send_frame(a, (k == 0) ? 8'h00 : (k == 7) ? 8'hFF : 8'((a * 37 + k * 29 + 3) & 255));

    // R3: every code value, channels in rotation
    for (int v = 0; v < 256; v++) send_frame(v % NCH, 8'(v));

    // R1: frame with three leading extra bits; only the last 11 count
    send_bits({2'b0, 3'b101, 3'd2, 8'h5A}, 14, 2, 8'h5A);
    send_bits({2'b0, 3'b011, 3'd5, 8'hC3}, 14, 5, 8'hC3);

    // R7: clock edges with select high must not shift
    send_frame(1, 8'h3C);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check_all("R7 no change on idle clocks");

    // R6: asynchronous preset, then reload held frame (R7)
    preset_n = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) check("R6 preset immediate", 32'(codes[c*8 +: 8]), 32'h80);
    tick(4);
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    check_all("R6 preset held");
    preset_n = 1'b1;
    tick(4);
    check_all("R6 after preset release");
    csel_n = 1'b0;
    tick(H);
    csel_n = 1'b1;
    tick(6);
    exp_code[1] = 8'h3C;
    check_all("R7 R6 reload of held frame");

    // R9: shutdown flag and untouched codes
    shdn = 1'b1;
    tick(4);
    check("R9 shutdown flag set", 32'(shdn_f), 32'h1);
    check_all("R9 codes kept in shutdown");
    shdn = 1'b0;
    tick(4);
    check("R9 shutdown flag clear", 32'(shdn_f), 32'h0);
    check_all("R9 codes kept after shutdown");

    report();
  end
endmodule